// File: doc/BRIEF.md
# Standalone Boundary-Scan Test Run Controller

This block runs one self-contained pass over a set of stored boundary-scan tests with no processor involved. A power-on reset input and a front-panel run switch are both active low. While either one is low the block holds itself and the external test flash in reset. When both are high, a run starts. The block lets the flash settle for a fixed time, then launches each stored test in turn on a test engine. The engine does the vector decoding, TAP shifting and signature work, and the block talks to it only through a start pulse, a test index, and a done/pass result.

Before every test after the first, the flash reset line is pulsed low again and the settle time is waited once more. A failure reported by any test is latched for the rest of the run. The pass/fail output stays low until the last test has reported, and then shows the latched result. The busy and run-active flags show the board that a run is in progress. A test-output-enable input lets all board-facing outputs float.

Top module: `bscan_run_ctrl`

## Requirements
- R1: Either `por_n` or `run_sw_n` at 0 resets the block. By the third rising clock edge after the low level appears, `flash_rst_n`, `run_active`, `busy` and `fail` are all 0, and they stay 0 while the low level is held.
- R2: When both start inputs are 1, at the third rising edge after the later one rose, `flash_rst_n`, `run_active` and `busy` become 1.
- R3: The first `test_start` rises exactly WAIT_CYC cycles after `run_active` rises, with `test_sel` = 0. WAIT_CYC is CLK_KHZ*WAIT_US/1000 master-clock cycles. `test_start` is high for exactly one cycle.
- R4: A result accepted for a test that is not the last drives `flash_rst_n` low for exactly PULSE_CYC cycles from the next cycle. After it rises, the next `test_start` follows exactly WAIT_CYC cycles later, with `test_sel` one higher than before.
- R5: `eng_done` has no effect unless the block is waiting for a result after a `test_start`. Outside that window, a pulse on it changes neither the timing nor the final `fail`.
- R6: `fail` stays 0 while a run is in progress. After the run ends, `fail` is 1 if and only if at least one test returned `eng_pass` = 0, whichever test it was.
- R7: In the cycle after the last test's result is accepted, `busy` and `run_active` fall to 0. They stay 0, with `flash_rst_n` at 1, until the next reset event.
- R8: While `out_en` is 0, `flash_rst_n`, `run_active`, `busy` and `fail` are high impedance. They return to their driven values in the same cycle that `out_en` returns to 1.
- R9: A reset event in the middle of a run clears the latched failure, and the following run starts again from test index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset start source, active low, asynchronous |
| run_sw_n | input | 1 | Run-switch start source, active low, asynchronous |
| out_en | input | 1 | Test output enable; 0 floats the board-facing outputs |
| eng_done | input | 1 | Test engine reports the current test has finished |
| eng_pass | input | 1 | Result qualifier with eng_done: 1 pass, 0 data error |
| test_start | output | 1 | One-cycle pulse launching the selected test on the engine |
| test_sel | output | IDX_W | Index of the test being launched or run |
| flash_rst_n | output | 1 | Reset to the external test flash, active low |
| run_active | output | 1 | High from release of reset until the run ends |
| busy | output | 1 | High while stored tests are executing |
| fail | output | 1 | 1 after the run if any test failed; 0 otherwise and during the run |

## Verification
Each start input passes two synchronizer flops before the state register, so a level change at a start pin shows at the outputs after the third rising edge. The bench drives each change at a falling edge and looks three falling edges later. Settle and pulse windows are measured rather than predicted to a point: the bench counts falling edges from one observed output event to the next and compares the count with WAIT_CYC or PULSE_CYC. An engine result driven at a falling edge is taken at the next rising edge, so the flash pulse or end-of-run flags are due at the falling edge right after that. The output-enable path is purely combinational and is checked at the following falling edge.

// File: rtl/rc_pkg.sv
package rc_pkg;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_SETTLE,
      ST_LAUNCH,
      ST_AWAIT,
      ST_FPULSE,
      ST_END
   } rc_state_e;

   function automatic int unsigned rc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rc_start_sync.sv
module rc_start_sync (
   input  logic clk,
   input  logic por_n,
   input  logic run_sw_n,
   output logic run_en
);

   logic [1:0] por_q;
   logic [1:0] sw_q;

   always_ff @(posedge clk) begin
      por_q <= {por_q[0], por_n};
      sw_q  <= {sw_q[0], run_sw_n};
   end

   assign run_en = por_q[1] & sw_q[1];

   // R1: a low seen on either first stage reaches the run enable one edge later
   p_low_resets_r1: assert property (@(posedge clk) !(por_q[0] & sw_q[0]) |=> !run_en);

endmodule

// File: rtl/rc_wait_timer.sv
module rc_wait_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R3: a nonzero load cannot report expiry in the following cycle
   p_no_early_expire_r3: assert property (@(posedge clk) (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/rc_fail_latch.sv
module rc_fail_latch (
   input  logic clk,
   input  logic clr,
   input  logic set,
   output logic fail_q
);

   always_ff @(posedge clk) begin
      if (clr)
         fail_q <= 1'b0;
      else if (set)
         fail_q <= 1'b1;
   end

   // R6: once a failure is latched it holds until the next reset event
   p_sticky_fail_r6: assert property (@(posedge clk) disable iff (clr) fail_q |=> fail_q);

endmodule

// File: rtl/bscan_run_ctrl.sv
module bscan_run_ctrl
   import rc_pkg::*;
#(
   parameter int unsigned NUM_TESTS   = 4,
   parameter int unsigned CLK_KHZ     = 66000,
   parameter int unsigned WAIT_US     = 150,
   parameter int unsigned PULSE_CYC   = 16,
   parameter bit          FLOAT_ON_OE = 1'b1,
   localparam int unsigned IDX_W      = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             run_sw_n,
   input  logic             out_en,
   input  logic             eng_done,
   input  logic             eng_pass,
   output logic             test_start,
   output logic [IDX_W-1:0] test_sel,
   output logic             flash_rst_n,
   output logic             run_active,
   output logic             busy,
   output logic             fail
);

   localparam int unsigned WAIT_CYC = (CLK_KHZ * WAIT_US) / 1000;
   localparam int unsigned TMR_W    = $clog2(rc_max(WAIT_CYC, PULSE_CYC) + 1);
   localparam logic [TMR_W-1:0] WAIT_LD  = TMR_W'(WAIT_CYC - 1);
   localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TESTS - 1);

   initial begin
      if (NUM_TESTS < 1)  $error("NUM_TESTS must be at least 1");
      if (WAIT_CYC < 1)   $error("settle time must span at least one clock");
      if (PULSE_CYC < 1)  $error("PULSE_CYC must be at least 1");
   end

   logic             run_en;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             fail_q;
   logic             accept;
   rc_state_e        state_q;
   logic [IDX_W-1:0] idx_q;

   logic flash_rst_n_i, run_active_i, busy_i, fail_i;

   rc_start_sync u_sync (
      .clk      (clk),
      .por_n    (por_n),
      .run_sw_n (run_sw_n),
      .run_en   (run_en)
   );

   rc_wait_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   assign accept = (state_q == ST_AWAIT) && eng_done;

   rc_fail_latch u_fail (
      .clk    (clk),
      .clr    (!run_en),
      .set    (accept && !eng_pass),
      .fail_q (fail_q)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = WAIT_LD;
      if (state_q == ST_HOLD || (state_q == ST_FPULSE && tmr_zero)) begin
         tmr_load = 1'b1;
         tmr_val  = WAIT_LD;
      end else if (accept && idx_q != LAST_IDX) begin
         tmr_load = 1'b1;
         tmr_val  = PULSE_LD;
      end
   end

   always_ff @(posedge clk) begin
      if (!run_en) begin
         state_q <= ST_HOLD;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            ST_HOLD:   state_q <= ST_SETTLE;
            ST_SETTLE: if (tmr_zero) state_q <= ST_LAUNCH;
            ST_LAUNCH: state_q <= ST_AWAIT;
            ST_AWAIT: begin
               if (eng_done) begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= ST_END;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_FPULSE;
                  end
               end
            end
            ST_FPULSE: if (tmr_zero) state_q <= ST_SETTLE;
            ST_END:    state_q <= ST_END;
            default:   state_q <= ST_HOLD;
         endcase
      end
   end

   assign test_start    = (state_q == ST_LAUNCH);
   assign test_sel      = idx_q;
   assign flash_rst_n_i = (state_q != ST_HOLD) && (state_q != ST_FPULSE);
   assign run_active_i  = (state_q != ST_HOLD) && (state_q != ST_END);
   assign busy_i        = run_active_i;
   assign fail_i        = (state_q == ST_END) && fail_q;

   generate
      if (FLOAT_ON_OE) begin : g_float
         assign flash_rst_n = out_en ? flash_rst_n_i : 1'bz;
         assign run_active  = out_en ? run_active_i  : 1'bz;
         assign busy        = out_en ? busy_i        : 1'bz;
         assign fail        = out_en ? fail_i        : 1'bz;
      end else begin : g_driven
         logic unused_oe;
         assign unused_oe   = out_en;
         assign flash_rst_n = flash_rst_n_i;
         assign run_active  = run_active_i;
         assign busy        = busy_i;
         assign fail        = fail_i;
      end
   endgenerate

   // R3: launch is a single-cycle pulse
   p_start_pulse_r3: assert property (@(posedge clk) disable iff (!run_en)
      test_start |=> !test_start);
   // R4: the test index never leaves the stored range
   p_sel_range_r4: assert property (@(posedge clk) disable iff (!run_en)
      test_sel <= LAST_IDX);
   // R7: the run only ends in the cycle after an engine result
   p_end_after_result_r7: assert property (@(posedge clk) disable iff (!run_en)
      $fell(busy_i) |-> $past(eng_done));
   // R6: the latched verdict is never visible while running
   p_fail_hidden_r6: assert property (@(posedge clk) disable iff (!run_en)
      busy_i |-> !fail_i);

endmodule

// File: tb/tb_bscan_run_ctrl.sv
module tb_bscan_run_ctrl;

   localparam int unsigned NT = 3;
   localparam int unsigned W  = 20;  // 20000 kHz * 1 us
   localparam int unsigned P  = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0, run_sw_n = 1'b1, out_en = 1'b1;
   logic eng_done = 1'b0, eng_pass = 1'b1;
   wire  test_start;
   wire  [1:0] test_sel;
   wire  flash_rst_n, run_active, busy, fail;

   pullup (flash_rst_n);
   pullup (run_active);
   pullup (busy);
   pullup (fail);

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk;

   bscan_run_ctrl #(
      .NUM_TESTS(NT), .CLK_KHZ(20000), .WAIT_US(1), .PULSE_CYC(P), .FLOAT_ON_OE(1'b1)
   ) dut (
      .clk(clk), .por_n(por_n), .run_sw_n(run_sw_n), .out_en(out_en),
      .eng_done(eng_done), .eng_pass(eng_pass), .test_start(test_start),
      .test_sel(test_sel), .flash_rst_n(flash_rst_n), .run_active(run_active),
      .busy(busy), .fail(fail)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         summary();
      end
   end

   // Hold chosen start input low, check reset outputs, release it and run all tests.
   task automatic run_seq(input logic [NT-1:0] mask, input bit via_sw, input bit spurious);
      int n, m, lo;
      bit exp_fail;
      exp_fail = (mask != {NT{1'b1}});
      @(negedge clk);
      if (via_sw) run_sw_n = 1'b0; else por_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(!flash_rst_n && !busy && !run_active && !fail, "R1",
          {flash_rst_n, busy, run_active, fail}, 0);
      if (via_sw) run_sw_n = 1'b1; else por_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!run_active && n < 50);
      chk(n == 3, "R2 release latency", n, 3);
      chk(flash_rst_n && busy, "R2 flash/busy high", {flash_rst_n, busy}, 3);
      for (int i = 0; i < NT; i++) begin
         m = 0;
         while (!test_start && m < 1000) begin
            if (spurious && i == 0 && m == 5) begin eng_done = 1'b1; eng_pass = 1'b0; end
            if (spurious && i == 0 && m == 6) begin eng_done = 1'b0; eng_pass = 1'b1; end
            @(negedge clk); m++;
         end
         chk(m == W, (i == 0) ? "R3 settle before first test" : "R4 settle before next test", m, W);
         chk(test_sel == i[1:0], (i == 0) ? "R3 first index" : "R4 index step", test_sel, i);
         @(negedge clk);
         chk(!test_start, "R3 single-cycle launch", test_start, 0);
         eng_done = 1'b1; eng_pass = mask[i];
         @(negedge clk);
         eng_done = 1'b0; eng_pass = 1'b1;
         if (i == NT - 1) begin
            chk(!busy && !run_active, "R7 flags fall", {busy, run_active}, 0);
            chk(fail == exp_fail, "R6 final verdict", fail, exp_fail);
         end else begin
            chk(busy && !fail, "R6 verdict hidden while running", {busy, fail}, 2);
            lo = 0;
            while (!flash_rst_n && lo < 1000) begin lo++; @(negedge clk); end
            chk(lo == P, "R4 flash pulse width", lo, P);
         end
      end
      // R5: result pulse after the run is ignored
      eng_done = 1'b1; eng_pass = 1'b0;
      @(negedge clk);
      eng_done = 1'b0; eng_pass = 1'b1;
      repeat (5) @(negedge clk);
      chk(!busy && !run_active && flash_rst_n && !test_start, "R7 stays ended",
          {busy, run_active, flash_rst_n, test_start}, 2);
      chk(fail == exp_fail, "R5 late result ignored", fail, exp_fail);
   endtask

   task automatic t_reset_state();
      repeat (5) @(negedge clk);
      chk(!flash_rst_n && !busy && !run_active && !fail, "R1 power-up hold",
          {flash_rst_n, busy, run_active, fail}, 0);
   endtask

   task automatic t_float();
      @(negedge clk);
      por_n = 1'b0;
      repeat (4) @(negedge clk);
      out_en = 1'b0;
      @(negedge clk);
      chk(flash_rst_n && busy && run_active && fail, "R8 outputs float",
          {flash_rst_n, busy, run_active, fail}, 15);
      out_en = 1'b1;
      @(negedge clk);
      chk(!flash_rst_n && !busy && !run_active && !fail, "R8 outputs driven again",
          {flash_rst_n, busy, run_active, fail}, 0);
   endtask

   task automatic t_abort();
      int n;
      @(negedge clk);
      por_n = 1'b0;
      repeat (4) @(negedge clk);
      por_n = 1'b1;
      n = 0;
      while (!test_start && n < 1000) begin @(negedge clk); n++; end
      @(negedge clk);
      eng_done = 1'b1; eng_pass = 1'b0;
      @(negedge clk);
      eng_done = 1'b0; eng_pass = 1'b1;
      repeat (2) @(negedge clk);
      run_sw_n = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (busy && n < 50);
      chk(n == 3, "R1 mid-run reset latency", n, 3);
      chk(!flash_rst_n, "R1 flash held in reset", flash_rst_n, 0);
      // R9: restart by switch, all pass: verdict cleared, index restarts at 0
      run_seq(3'b111, 1'b1, 1'b0);
   endtask

   initial begin
      t_reset_state();
      run_seq(3'b111, 1'b0, 1'b1);
      run_seq(3'b101, 1'b0, 1'b0);
      run_seq(3'b110, 1'b1, 1'b0);
      t_float();
      t_abort();
      summary();
   end

endmodule